// File: doc/BRIEF.md
# Flash Read Timing Calibration Sequencer

This block tunes the read path of a serial flash controller without software help. When started, it sets the controller to a slow, safe clock and reads a reference block of the flash window into an internal RAM. It keeps that block only if enough of its words carry mixed bits. If too few do, it stops at once and leaves the slow setting in place.

With a usable reference, the block works through the clock dividers from the slowest to the fastest allowed one. For each divider it steps through twelve input-delay settings. It judges each setting by reading the whole block several times and comparing every word with the reference. Three passing settings in a row end the sweep for that divider, and the engine then keeps the middle one of the three as its safety margin. After the last divider, the fastest divider that found a setting is written out together with its delay nibble. If none found one, the slow default is restored and a failure is flagged.

The flash controller consumes the configuration outputs directly. A single-word read port gives the block access to the flash window. Requests are held until the controller returns data.

Top module: `calib_engine`

## Requirements
- R1: A `start_i` pulse in idle first loads `div_code_o` = SLOW_CODE and `timing_o` = 0, then reads words 0 to WORDS-1 of the window exactly once into the reference RAM under that setting.
- R2: A word is varied when it is neither all zeros nor all ones. If fewer than MIN_VARIED captured words are varied, the engine issues no further reads, reloads the slow setting and ends with `fail_o` = 1.
- R3: A delay setting passes only when REPS successive reads of the whole block all equal the reference. The first mismatching word ends that setting's test at once, so a corrupt word k in repetition r costs r·WORDS+k+1 reads.
- R4: Step i (0 to 11) uses nibble {i even, i/2[2:0]}, with bit 3 as the extra-delay flag. For divider d this nibble is placed at `timing_o` bits [(d-1)·4 +: 4] and all other bits are zero. Steps are applied in increasing i.
- R5: A failing step clears the run of consecutive passes. When the third pass in a row is seen at step i, the sweep for that divider ends and step i-1 is recorded.
- R6: Divider codes on `div_code_o` are 4'hF for /1, 4'h7 for /2, 4'hE for /3, 4'h6 for /4 and 4'hD for /5.
- R7: Dividers are tried from 5 down to 1. The sweep stops before the first divider below `min_div_i`, so with `min_div_i` above 5 no divider is tried.
- R8: If any divider recorded a step, the final write carries the smallest such divider's code, with its recorded nibble placed as in R4, and `fail_o` = 0.
- R9: If no divider recorded a step, the final write restores SLOW_CODE with `timing_o` = 0, and `fail_o` = 1.
- R10: `done_o` is a one-cycle pulse. It coincides with the final configuration write. `div_code_o` and `timing_o` change only in cycles where `cfg_we_o` is 1.
- R11: While `rd_req_o` is high and `rd_vld_i` is low, `rd_req_o` stays high and `rd_addr_o` stays fixed. A word is taken in the cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a calibration when idle |
| min_div_i | input | 3 | Smallest divider allowed by the flash's maximum frequency |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| fail_o | output | 1 | Result flag, valid from done until the next start |
| rd_req_o | output | 1 | Word read request into the flash window |
| rd_addr_o | output | $clog2(WORDS) | Word index of the request |
| rd_vld_i | input | 1 | Read data valid, completes the request |
| rd_data_i | input | 32 | Read data word |
| cfg_we_o | output | 1 | Strobe marking a new configuration value |
| div_code_o | output | 4 | Clock divider field for the controller |
| timing_o | output | 32 | Read timing register value |

## Verification
A configuration write appears on `div_code_o`, `timing_o` and `cfg_we_o` one cycle after the edge that decides it. The first read request of a step follows one cycle later. `done_o` rises two cycles after the last word of a test is accepted. The bench acts as the flash and stalls one cycle in three. It samples on the falling edge and records a log entry each time `cfg_we_o` is high. It credits every accepted word to the entry active when that word was served. It compares the full log and the final outputs only one falling edge after `done_o`, so that the final write has been recorded.

// File: rtl/calib_pkg.sv
package calib_pkg;

  localparam int NUM_STEPS = 12;
  localparam int PASS_RUN  = 3;
  localparam int TIM_W     = 32;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CAPT,
    S_PICK,
    S_APPLY,
    S_TEST
  } cal_state_e;

  function automatic logic [3:0] div_code(input logic [2:0] d);
    case (d)
      3'd1:    return 4'hF;
      3'd2:    return 4'h7;
      3'd3:    return 4'hE;
      3'd4:    return 4'h6;
      3'd5:    return 4'hD;
      default: return 4'h0;
    endcase
  endfunction

  // even steps carry the extra input delay flag in bit 3
  function automatic logic [3:0] step_nib(input logic [3:0] i);
    return {~i[0], i[3:1]};
  endfunction

  function automatic logic [TIM_W-1:0] place_nib(input logic [2:0] d, input logic [3:0] n);
    logic [4:0] sh;
    sh = {d - 3'd1, 2'b00};
    return TIM_W'(n) << sh;
  endfunction

endpackage

// File: rtl/calib_ref_ram.sv
module calib_ref_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/calib_scan.sv
module calib_scan #(
  parameter int WORDS      = 256,
  parameter int REPS       = 10,
  parameter int MIN_VARIED = 64,
  parameter int DW         = 32,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          capture_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          match_o,
  output logic          varied_ok_o
);

  localparam int RW = $clog2(REPS + 1);
  localparam int VW = $clog2(MIN_VARIED + 1);

  logic          active_q, active_d;
  logic          cap_q, cap_d;
  logic [AW-1:0] word_q, word_d;
  logic [RW-1:0] rep_q, rep_d;
  logic [VW-1:0] vcnt_q, vcnt_d;
  logic          done_q, match_q, match_d;
  logic [DW-1:0] ref_word;
  logic          beat, last_word, last_rep, mism, finish, varied;

  calib_ref_ram #(.WORDS(WORDS), .DW(DW)) u_ref (
    .clk     (clk),
    .we_i    (beat & cap_q),
    .waddr_i (word_q),
    .wdata_i (rd_data_i),
    .raddr_i (word_q),
    .rdata_o (ref_word)
  );

  always_comb begin
    beat      = active_q & rd_vld_i;
    last_word = (word_q == AW'(WORDS - 1));
    last_rep  = cap_q | (rep_q == RW'(REPS - 1));
    mism      = ~cap_q & (rd_data_i != ref_word);
    finish    = beat & (mism | (last_word & last_rep));
    varied    = (rd_data_i != '0) & (rd_data_i != '1);
  end

  always_comb begin
    active_d = active_q;
    cap_d    = cap_q;
    word_d   = word_q;
    rep_d    = rep_q;
    vcnt_d   = vcnt_q;
    match_d  = match_q;
    if (go_i) begin
      active_d = 1'b1;
      cap_d    = capture_i;
      word_d   = '0;
      rep_d    = '0;
      if (capture_i) vcnt_d = '0;
    end else if (beat) begin
      if (finish) begin
        active_d = 1'b0;
        match_d  = ~mism;
      end else begin
        word_d = last_word ? '0 : word_q + 1'b1;
        if (last_word) rep_d = rep_q + 1'b1;
      end
      if (cap_q && varied && vcnt_q != VW'(MIN_VARIED)) vcnt_d = vcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cap_q    <= 1'b0;
      word_q   <= '0;
      rep_q    <= '0;
      vcnt_q   <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cap_q    <= cap_d;
      word_q   <= word_d;
      rep_q    <= rep_d;
      vcnt_q   <= vcnt_d;
      done_q   <= finish;
      match_q  <= match_d;
    end
  end

  assign rd_req_o    = active_q;
  assign rd_addr_o   = word_q;
  assign done_o      = done_q;
  assign match_o     = match_q;
  assign varied_ok_o = (vcnt_q == VW'(MIN_VARIED));

  // R11: a pending request holds its address until data arrives
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_vld_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R3: a finished test has no request left outstanding
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  a_r3_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rep_q < RW'(REPS)));

endmodule

// File: rtl/calib_sweep.sv
module calib_sweep
  import calib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       res_vld_i,
  input  logic       res_pass_i,
  output logic [3:0] step_o,
  output logic [3:0] pick_o,
  output logic       accept_o,
  output logic       exhausted_o
);

  logic [3:0] step_q, step_d;
  logic [1:0] run_q, run_d;

  always_comb begin
    accept_o    = res_vld_i & res_pass_i & (run_q == 2'(PASS_RUN - 1));
    exhausted_o = res_vld_i & ~accept_o & (step_q == 4'(NUM_STEPS - 1));
    pick_o      = step_q - 4'd1;
  end

  always_comb begin
    step_d = step_q;
    run_d  = run_q;
    if (clear_i) begin
      step_d = '0;
      run_d  = '0;
    end else if (res_vld_i && !accept_o && !exhausted_o) begin
      step_d = step_q + 4'd1;
      run_d  = res_pass_i ? run_q + 2'd1 : 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      run_q  <= '0;
    end else begin
      step_q <= step_d;
      run_q  <= run_d;
    end
  end

  assign step_o = step_q;

  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < 2'(PASS_RUN));

  a_r5_accept_late: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (step_q >= 4'(PASS_RUN - 1)));

  a_r4_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_q < 4'(NUM_STEPS));

endmodule

// File: rtl/calib_engine.sv
module calib_engine
  import calib_pkg::*;
#(
  parameter int         WORDS      = 256,
  parameter int         REPS       = 10,
  parameter int         MIN_VARIED = 64,
  parameter logic [3:0] SLOW_CODE  = 4'h0,
  localparam int        AW         = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       min_div_i,
  output logic             done_o,
  output logic             fail_o,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_vld_i,
  input  logic [31:0]      rd_data_i,
  output logic             cfg_we_o,
  output logic [3:0]       div_code_o,
  output logic [TIM_W-1:0] timing_o
);

  cal_state_e       state_q, state_d;
  logic [2:0]       div_q, div_d, best_div_q, best_div_d;
  logic [3:0]       best_nib_q, best_nib_d;
  logic [3:0]       code_q, code_d;
  logic [TIM_W-1:0] tim_q, tim_d;
  logic             we_q, load, done_q, done_d, fail_q, fail_d;
  logic             scan_go, scan_cap, scan_done, scan_match, varied_ok;
  logic             sw_clear, sw_vld, sw_accept, sw_exh;
  logic [3:0]       sw_step, sw_pick;

  calib_scan #(.WORDS(WORDS), .REPS(REPS), .MIN_VARIED(MIN_VARIED), .DW(32)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (scan_go),
    .capture_i   (scan_cap),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o),
    .rd_vld_i    (rd_vld_i),
    .rd_data_i   (rd_data_i),
    .done_o      (scan_done),
    .match_o     (scan_match),
    .varied_ok_o (varied_ok)
  );

  assign sw_vld = scan_done & (state_q == S_TEST);

  calib_sweep u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (sw_clear),
    .res_vld_i   (sw_vld),
    .res_pass_i  (scan_match),
    .step_o      (sw_step),
    .pick_o      (sw_pick),
    .accept_o    (sw_accept),
    .exhausted_o (sw_exh)
  );

  always_comb begin
    state_d    = state_q;
    div_d      = div_q;
    best_div_d = best_div_q;
    best_nib_d = best_nib_q;
    load       = 1'b0;
    code_d     = code_q;
    tim_d      = tim_q;
    done_d     = 1'b0;
    fail_d     = fail_q;
    scan_go    = 1'b0;
    scan_cap   = 1'b0;
    sw_clear   = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        load     = 1'b1;
        code_d   = SLOW_CODE;
        tim_d    = '0;
        fail_d   = 1'b0;
        scan_go  = 1'b1;
        scan_cap = 1'b1;
        state_d  = S_CAPT;
      end
      S_CAPT: if (scan_done) begin
        if (!varied_ok) begin
          load    = 1'b1;
          code_d  = SLOW_CODE;
          tim_d   = '0;
          done_d  = 1'b1;
          fail_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          div_d      = 3'd5;
          best_div_d = '0;
          state_d    = S_PICK;
        end
      end
      S_PICK: begin
        if (div_q == 3'd0 || div_q < min_div_i) begin
          load    = 1'b1;
          done_d  = 1'b1;
          state_d = S_IDLE;
          if (best_div_q != 3'd0) begin
            code_d = div_code(best_div_q);
            tim_d  = place_nib(best_div_q, best_nib_q);
            fail_d = 1'b0;
          end else begin
            code_d = SLOW_CODE;
            tim_d  = '0;
            fail_d = 1'b1;
          end
        end else begin
          sw_clear = 1'b1;
          state_d  = S_APPLY;
        end
      end
      S_APPLY: begin
        load    = 1'b1;
        code_d  = div_code(div_q);
        tim_d   = place_nib(div_q, step_nib(sw_step));
        scan_go = 1'b1;
        state_d = S_TEST;
      end
      S_TEST: if (scan_done) begin
        if (sw_accept) begin
          best_div_d = div_q;
          best_nib_d = step_nib(sw_pick);
          div_d      = div_q - 3'd1;
          state_d    = S_PICK;
        end else if (sw_exh) begin
          div_d   = div_q - 3'd1;
          state_d = S_PICK;
        end else begin
          state_d = S_APPLY;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      div_q      <= '0;
      best_div_q <= '0;
      best_nib_q <= '0;
      code_q     <= SLOW_CODE;
      tim_q      <= '0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      div_q      <= div_d;
      best_div_q <= best_div_d;
      best_nib_q <= best_nib_d;
      we_q       <= load;
      done_q     <= done_d;
      fail_q     <= fail_d;
      if (load) begin
        code_q <= code_d;
        tim_q  <= tim_d;
      end
    end
  end

  assign cfg_we_o   = we_q;
  assign div_code_o = code_q;
  assign timing_o   = tim_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r10_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cfg_we_o);

  a_r10_quiet_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    ((div_code_o != $past(div_code_o)) || (timing_o != $past(timing_o))) |-> cfg_we_o);

  a_r1_capture_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CAPT && rd_req_o) |-> (div_code_o == SLOW_CODE && timing_o == '0));

  a_r9_fail_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> (div_code_o == SLOW_CODE && timing_o == '0));

  a_r7_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TEST) |-> (div_q >= 3'd1 && div_q <= 3'd5));

endmodule

// File: tb/tb_calib_engine.sv
module tb_calib_engine;
  import calib_pkg::*;

  localparam int         W    = 16;
  localparam int         REPS = 3;
  localparam int         MINV = 4;
  localparam logic [3:0] SLOW = 4'h0;
  localparam int         AW   = $clog2(W);

  logic             clk, rst_n, start_i, done_o, fail_o, rd_req_o, rd_vld_i, cfg_we_o;
  logic [2:0]       min_div_i;
  logic [AW-1:0]    rd_addr_o;
  logic [31:0]      rd_data_i;
  logic [3:0]       div_code_o;
  logic [TIM_W-1:0] timing_o;

  calib_engine #(.WORDS(W), .REPS(REPS), .MIN_VARIED(MINV), .SLOW_CODE(SLOW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .min_div_i(min_div_i),
    .done_o(done_o), .fail_o(fail_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i), .cfg_we_o(cfg_we_o),
    .div_code_o(div_code_o), .timing_o(timing_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  logic [11:0] okm [1:5];
  int flaky_d, flaky_i, bad_word, varied_n;
  logic [7:0] seed;

  logic [3:0]  got_code [128];
  logic [31:0] got_tim  [128];
  int          got_wd   [128];
  int          got_n;
  logic [3:0]  exp_code [128];
  logic [31:0] exp_tim  [128];
  int          exp_wd   [128];
  int          exp_n;

  function automatic logic [3:0] code_of(int d);
    case (d)
      1: return 4'hF; 2: return 4'h7; 3: return 4'hE; 4: return 4'h6; 5: return 4'hD;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [3:0] nib_of(int i);
    return {(i % 2 == 0), 3'(i / 2)};
  endfunction

  function automatic logic [31:0] golden(int w);
    if (w < varied_n) return {8'hA5, seed, 8'(w), 8'h3C};
    return (w % 2 == 0) ? 32'h0 : 32'hFFFF_FFFF;
  endfunction

  function automatic bit step_ok(int d, int i);
    return okm[d][i] && !(d == flaky_d && i == flaky_i);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flash model and log recorder
  initial begin
    bit pend, last_req, last_vld;
    logic [AW-1:0] last_addr;
    int cyc;
    pend = 0; last_req = 0; last_vld = 0; last_addr = '0; cyc = 0;
    rd_vld_i = 1'b0; rd_data_i = '0; got_n = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend && got_n > 0) got_wd[got_n-1]++;
      if (cfg_we_o && got_n < 128) begin
        got_code[got_n] = div_code_o;
        got_tim[got_n]  = timing_o;
        got_wd[got_n]   = 0;
        got_n++;
      end
      if (last_req && !last_vld)
        check(rd_req_o && rd_addr_o == last_addr, "R11", "held request address",
              longint'(rd_addr_o), longint'(last_addr));
      rd_vld_i  = rd_req_o && (cyc % 3 != 1);
      rd_data_i = golden(int'(rd_addr_o));
      if (rd_req_o && div_code_o != SLOW && got_n > 0) begin
        int d, i, rep;
        logic [3:0] n;
        d = 0;
        for (int k = 1; k <= 5; k++) if (code_of(k) == div_code_o) d = k;
        if (d != 0) begin
          n   = 4'(timing_o >> (4 * (d - 1)));
          i   = 2 * int'(n[2:0]) + (n[3] ? 0 : 1);
          rep = got_wd[got_n-1] / W;
          if (int'(rd_addr_o) == bad_word &&
              (!okm[d][i] || (d == flaky_d && i == flaky_i && rep == REPS - 1)))
            rd_data_i = rd_data_i ^ 32'h0000_0100;
        end
      end
      pend      = rd_vld_i && rd_req_o;
      last_req  = rd_req_o;
      last_vld  = rd_vld_i;
      last_addr = rd_addr_o;
    end
  end

  task automatic push(input logic [3:0] c, input logic [31:0] t, input int wd);
    exp_code[exp_n] = c; exp_tim[exp_n] = t; exp_wd[exp_n] = wd; exp_n++;
  endtask

  task automatic run_case(input int vn, input int md, input int bw);
    int best, bn, run, cycles;
    bit exp_fail, saw_done;
    varied_n = vn; bad_word = bw; min_div_i = 3'(md);
    exp_n = 0; best = 0; bn = 0;
    push(SLOW, 0, W);
    if (vn < MINV) begin
      push(SLOW, 0, 0);
    end else begin
      for (int d = 5; d >= 1; d--) begin
        if (d < md) break;
        run = 0;
        for (int i = 0; i < NUM_STEPS; i++) begin
          bit p;
          p = step_ok(d, i);
          push(code_of(d), 32'(nib_of(i)) << (4 * (d - 1)),
               p ? REPS * W : ((d == flaky_d && i == flaky_i) ? (REPS - 1) * W + bw + 1 : bw + 1));
          if (p) begin
            run++;
            if (run == 3) begin best = d; bn = i - 1; break; end
          end else run = 0;
        end
      end
      if (best != 0) push(code_of(best), 32'(nib_of(bn)) << (4 * (best - 1)), 0);
      else push(SLOW, 0, 0);
    end
    exp_fail = (best == 0);
    got_n = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cycles = 0; saw_done = 0;
    while (!saw_done && cycles < 40000) begin
      @(negedge clk);
      cycles++;
      saw_done = done_o;
    end
    check(saw_done, "R10", "done seen before watchdog", longint'(saw_done), 1);
    check(fail_o == exp_fail, exp_fail ? "R9" : "R8", "fail flag", longint'(fail_o), longint'(exp_fail));
    check(div_code_o == exp_code[exp_n-1], exp_fail ? "R9" : "R8", "final divider code",
          longint'(div_code_o), longint'(exp_code[exp_n-1]));
    check(timing_o == exp_tim[exp_n-1], exp_fail ? "R9" : "R8", "final timing",
          longint'(timing_o), longint'(exp_tim[exp_n-1]));
    @(negedge clk);
    check(!done_o, "R10", "done is one cycle", longint'(done_o), 0);
    check(got_n == exp_n, "R7", "configuration write count", longint'(got_n), longint'(exp_n));
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      check(got_code[k] == exp_code[k], "R6", "divider code in log",
            longint'(got_code[k]), longint'(exp_code[k]));
      check(got_tim[k] == exp_tim[k], "R4", "timing value in log",
            longint'(got_tim[k]), longint'(exp_tim[k]));
      check(got_wd[k] == exp_wd[k], (k == 0) ? "R1" : "R3", "words read under setting",
            longint'(got_wd[k]), longint'(exp_wd[k]));
    end
    if (vn < MINV)
      check(got_n == 2 && got_wd[1] == 0, "R2", "no reads after uniform capture",
            longint'(got_n), 2);
  endtask

  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0; start_i = 1'b0; min_div_i = 3'd1;
    flaky_d = 0; flaky_i = 0; seed = 8'h11; varied_n = W; bad_word = 0;
    for (int d = 1; d <= 5; d++) okm[d] = 12'hFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !fail_o && !rd_req_o && !cfg_we_o, "R10", "reset outputs quiet",
          longint'({done_o, fail_o, rd_req_o, cfg_we_o}), 0);
    check(div_code_o == SLOW && timing_o == 0, "R1", "reset configuration",
          longint'(div_code_o), longint'(SLOW));

    // R2: one varied word short of the threshold
    run_case(MINV - 1, 1, 0);
    // R2 boundary: exactly enough varied words, every setting good, R5 picks step 1
    run_case(MINV, 1, 3);
    // R9: nothing passes anywhere
    for (int d = 1; d <= 5; d++) okm[d] = 12'h000;
    run_case(W, 1, W - 1);
    // R7: minimum divider above 5, no divider tried
    for (int d = 1; d <= 5; d++) okm[d] = 12'hFFF;
    run_case(W, 6, 0);
    // R5: run broken at step 2 on divider 5, accepted at step 5
    for (int d = 1; d <= 4; d++) okm[d] = 12'h000;
    okm[5] = 12'b0000_0011_1011;
    run_case(W, 1, 7);
    // R3: divider 4 fails only on its last repetition at step 1
    okm[5] = 12'h000; okm[4] = 12'hFFF; flaky_d = 4; flaky_i = 1;
    run_case(W, 1, 5);
    flaky_d = 0;
    // R7/R8: pseudo-random pass maps with varying frequency limits
    lcg = 32'h1234_5678;
    for (int c = 0; c < 8; c++) begin
      for (int d = 1; d <= 5; d++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        okm[d] = lcg[27:16] | lcg[19:8];
      end
      seed = 8'(lcg[7:0]);
      run_case(W, (c % 4) + 1, c % W);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule